// File: doc/BRIEF.md
# Plane-Interleaved Dot Matrix Scanner

This block produces the scan timing and the video RAM byte addresses for a 128 by 32 dot-matrix display that gets its grey levels from four PWM planes. A single 7-bit scan counter carries the plane number in its two low bits and the physical row in its upper five bits. Because of this, each physical row is scanned four times in a row, once per plane, before the scan goes on to the next row. In the RAM address the same plane bits sit above the row bits, so every plane occupies its own contiguous 512-byte block.

A host programs four small registers through a write-only port: a column start, a row start, a code page and a control register. The scanner then runs on its own. Each row lasts 314 video clocks. In the first 256 of them the row's dots are shifted out, one dot every two video clocks. The remaining 58 video clocks are the column-latch phase. After 128 scanned rows (32 rows times 4 planes) the block gives a one-clock interrupt pulse and reloads its scan position from the host registers.

A parameter picks between two board variants. In the default variant the video clock runs at a quarter of the system clock and the plane bits reload as the constant 01. In the direct variant the video clock equals the system clock and the plane bits reload from two bits of the row start register.

Top module: `dmd_plane_scanner`

## Requirements
- R1: The video clock is a clock enable. It is active on every system clock when `DIRECT_VCLK`=1 and on every fourth system clock when `DIRECT_VCLK`=0. Successive `row_adv` pulses are therefore 314 system clocks apart in the first case and 1256 in the second.
- R2: Within a row, `shift_en` is high for video clocks 0..255 and `col_latch` is high for video clocks 256..313. `dot_clk` is high on the odd video clocks inside 0..255, which gives 128 dot pulses per row.
- R3: `row_adv` is a single-system-clock pulse during the last video clock (313) of each row.
- R4: At every row start, `ram_addr[3:0]` loads from COLSTART bits 6..3. It then advances by one, modulo 16, after every 16 video clocks of the shift phase. COLSTART bits 2..0 have no effect on any output.
- R5: The scan counter advances by one at every row end. `ram_addr[8:4]` shows counter bits 6..2, so four consecutive rows share the same row address.
- R6: `ram_addr[10:9]` shows counter bits 1..0 while the plane enable latched at the last interrupt is 1, and shows 00 while it is 0. At an interrupt the counter's low bits reload from ROWSTART bits 6..5 in the direct variant and from the constant 01 in the divided variant.
- R7: `irq` is a one-system-clock pulse. It coincides with the `row_adv` that ends every 128th row, which is 40192 video clocks apart. At that edge the counter reloads with ROWSTART bits 4..0 in counter bits 6..2.
- R8: `ram_addr[14:11]` follows CODEPAGE from the clock after it is written, without waiting for a reload point.
- R9: The register port decodes `wr_sel` as follows: 0 = COLSTART (7 bits), 1 = ROWSTART (7 bits), 2 = CODEPAGE (4 bits), 3 = control (bit 0 = plane enable). A write on the same edge as a reload does not affect that reload, because the reload uses the previous value.
- R10: During reset, `ram_addr` is 0, `irq`, `row_adv`, `dot_clk` and `col_latch` are 0, and `shift_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| ram_addr | output | 15 | Video RAM byte address |
| dot_clk | output | 1 | Dot shift clock |
| shift_en | output | 1 | High while dot data is shifted out |
| col_latch | output | 1 | End-of-row column latch phase |
| row_adv | output | 1 | Row advance pulse |
| irq | output | 1 | Frame-group interrupt pulse |

## Verification
The end of the 128th row makes `row_adv` and `irq` fire in the same clock. On that edge the column, the counter and the plane enable all reload at once. The bench also writes ROWSTART in exactly that interrupt cycle, so the host write and the reload collide. The row and plane address seen in the following cycle must come from the value written earlier, not from the colliding write. A behavioural model, compared with the outputs on every clock, judges the whole scan sequence across both plane-enable settings. Interval counters separately confirm the row period and the interrupt period in both clock variants.

// File: rtl/dmd_scan_pkg.sv
package dmd_scan_pkg;
  typedef enum logic [1:0] {
    SEL_COLSTART = 2'd0,
    SEL_ROWSTART = 2'd1,
    SEL_CODEPAGE = 2'd2,
    SEL_CONTROL  = 2'd3
  } reg_sel_e;

  localparam int unsigned ROW_VCLKS   = 314;
  localparam int unsigned SHIFT_VCLKS = 256;
  localparam int unsigned DOTS_PER_BYTE = 8;
endpackage

// File: rtl/dmd_vclk_div.sv
module dmd_vclk_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_divided
      localparam int unsigned DW = $clog2(DIV);
      logic [DW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == DW'(DIV - 1));

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;
    end
  endgenerate
endmodule

// File: rtl/dmd_row_seq.sv
module dmd_row_seq #(
  parameter int unsigned ROW_VCLKS   = 314,
  parameter int unsigned SHIFT_VCLKS = 256,
  parameter int unsigned BYTE_VCLKS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic shift_en,
  output logic dot_clk,
  output logic col_latch,
  output logic row_end,
  output logic byte_end
);
  localparam int unsigned POS_W   = $clog2(ROW_VCLKS);
  localparam int unsigned BYTE_SH = $clog2(BYTE_VCLKS);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             last_pos;

  assign last_pos = (pos_q == POS_W'(ROW_VCLKS - 1));

  always_comb begin
    pos_d = pos_q;
    if (tick) pos_d = last_pos ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign shift_en  = (pos_q < POS_W'(SHIFT_VCLKS));
  assign dot_clk   = shift_en & pos_q[0];
  assign col_latch = ~shift_en;
  assign row_end   = tick & last_pos;
  assign byte_end  = tick & shift_en & (&pos_q[BYTE_SH-1:0]);
endmodule

// File: rtl/dmd_scan_addr.sv
module dmd_scan_addr #(
  parameter int unsigned COL_W   = 4,
  parameter int unsigned ROW_W   = 5,
  parameter int unsigned PLANE_W = 2,
  parameter int unsigned PAGE_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  row_end,
  input  logic                                  byte_end,
  input  logic [COL_W-1:0]                      col_seed,
  input  logic [ROW_W+PLANE_W-1:0]              cnt_seed,
  input  logic                                  pe_seed,
  input  logic [PAGE_W-1:0]                     page,
  output logic [PAGE_W+PLANE_W+ROW_W+COL_W-1:0] addr,
  output logic                                  frame_end
);
  localparam int unsigned CNT_W = ROW_W + PLANE_W;

  logic [COL_W-1:0] col_q, col_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] scnt_q, scnt_d;
  logic             pe_q, pe_d;
  logic [PLANE_W-1:0] plane_vis;

  assign frame_end = row_end & (&scnt_q);

  always_comb begin
    col_d  = col_q;
    cnt_d  = cnt_q;
    scnt_d = scnt_q;
    pe_d   = pe_q;
    if (row_end)       col_d = col_seed;
    else if (byte_end) col_d = col_q + 1'b1;
    if (row_end) scnt_d = scnt_q + 1'b1;
    if (frame_end) begin
      cnt_d = cnt_seed;
      pe_d  = pe_seed;
    end else if (row_end) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      cnt_q  <= '0;
      scnt_q <= '0;
      pe_q   <= 1'b0;
    end else begin
      col_q  <= col_d;
      cnt_q  <= cnt_d;
      scnt_q <= scnt_d;
      pe_q   <= pe_d;
    end
  end

  assign plane_vis = pe_q ? cnt_q[PLANE_W-1:0] : '0;
  assign addr = {page, plane_vis, cnt_q[CNT_W-1:PLANE_W], col_q};
endmodule

// File: rtl/dmd_plane_scanner.sv
module dmd_plane_scanner #(
  parameter bit          DIRECT_VCLK = 1'b0,
  parameter int unsigned COL_W       = 4,
  parameter int unsigned ROW_W       = 5,
  parameter int unsigned PAGE_W      = 4,
  localparam int unsigned PLANE_W    = 2,
  localparam int unsigned ADDR_W     = PAGE_W + PLANE_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              dot_clk,
  output logic              shift_en,
  output logic              col_latch,
  output logic              row_adv,
  output logic              irq
);
  import dmd_scan_pkg::*;

  localparam int unsigned VDIV       = DIRECT_VCLK ? 1 : 4;
  localparam int unsigned BYTE_VCLKS = 2 * DOTS_PER_BYTE;
  localparam int unsigned SHIFT_BITS = 3;
  localparam int unsigned REG_W      = SHIFT_BITS + COL_W;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  // host registers
  logic [REG_W-1:0]         colstart_q, colstart_d;
  logic [ROW_W+PLANE_W-1:0] rowstart_q, rowstart_d;
  logic [PAGE_W-1:0]        codepage_q, codepage_d;
  logic                     pe_reg_q, pe_reg_d;

  always_comb begin
    colstart_d = colstart_q;
    rowstart_d = rowstart_q;
    codepage_d = codepage_q;
    pe_reg_d   = pe_reg_q;
    if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_COLSTART: colstart_d = wr_data[REG_W-1:0];
        SEL_ROWSTART: rowstart_d = wr_data[ROW_W+PLANE_W-1:0];
        SEL_CODEPAGE: codepage_d = wr_data[PAGE_W-1:0];
        SEL_CONTROL:  pe_reg_d   = wr_data[0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      colstart_q <= '0;
      rowstart_q <= '0;
      codepage_q <= '0;
      pe_reg_q   <= 1'b0;
    end else begin
      colstart_q <= colstart_d;
      rowstart_q <= rowstart_d;
      codepage_q <= codepage_d;
      pe_reg_q   <= pe_reg_d;
    end
  end

  // plane reload source per board variant
  logic [PLANE_W-1:0] plane_src;
  generate
    if (DIRECT_VCLK) begin : g_plane_reg
      assign plane_src = rowstart_q[ROW_W+PLANE_W-1:ROW_W];
    end else begin : g_plane_fixed
      assign plane_src = PLANE_W'(1);
    end
  endgenerate

  logic tick, byte_end, row_end, frame_end;

  dmd_vclk_div #(.DIV(VDIV)) u_div (
    .clk  (clk),
    .rst_n(rst_q),
    .tick (tick)
  );

  dmd_row_seq #(
    .ROW_VCLKS  (ROW_VCLKS),
    .SHIFT_VCLKS(SHIFT_VCLKS),
    .BYTE_VCLKS (BYTE_VCLKS)
  ) u_row (
    .clk      (clk),
    .rst_n    (rst_q),
    .tick     (tick),
    .shift_en (shift_en),
    .dot_clk  (dot_clk),
    .col_latch(col_latch),
    .row_end  (row_end),
    .byte_end (byte_end)
  );

  dmd_scan_addr #(
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .PLANE_W(PLANE_W),
    .PAGE_W (PAGE_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_q),
    .row_end  (row_end),
    .byte_end (byte_end),
    .col_seed (colstart_q[REG_W-1:SHIFT_BITS]),
    .cnt_seed ({rowstart_q[ROW_W-1:0], plane_src}),
    .pe_seed  (pe_reg_q),
    .page     (codepage_q),
    .addr     (ram_addr),
    .frame_end(frame_end)
  );

  assign row_adv = row_end;
  assign irq     = frame_end;
endmodule

// File: rtl/dmd_scan_chk.sv
module dmd_scan_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              dot_clk,
  input logic              col_latch,
  input logic              row_adv,
  input logic              irq,
  input logic [6:0]        colstart_q
);
  p_irq_on_row_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> row_adv);

  p_adv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> !row_adv);

  p_latch_after_dot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_latch) |-> $past(dot_clk));

  p_col_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> ram_addr[3:0] == $past(colstart_q[6:3]));

  p_page_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_sel == 2'd2) |-> ram_addr[ADDR_W-1:ADDR_W-4] == $past(wr_data[3:0]));
endmodule

bind dmd_plane_scanner dmd_scan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .ram_addr  (ram_addr),
  .dot_clk   (dot_clk),
  .col_latch (col_latch),
  .row_adv   (row_adv),
  .irq       (irq),
  .colstart_q(colstart_q)
);

// File: tb/dmd_plane_scanner_tb.sv
`timescale 1ns/1ps
module dmd_plane_scanner_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [14:0] ram_addr, ram_addr_d;
  logic        dot_clk, shift_en, col_latch, row_adv, irq;
  logic        dot_clk_d, shift_en_d, col_latch_d, row_adv_d, irq_d;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  dmd_plane_scanner #(.DIRECT_VCLK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ram_addr(ram_addr), .dot_clk(dot_clk), .shift_en(shift_en),
    .col_latch(col_latch), .row_adv(row_adv), .irq(irq));

  dmd_plane_scanner #(.DIRECT_VCLK(1'b0)) u_dut_div (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ram_addr(ram_addr_d), .dot_clk(dot_clk_d), .shift_en(shift_en_d),
    .col_latch(col_latch_d), .row_adv(row_adv_d), .irq(irq_d));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference for the direct-clock instance
  int rel, mpos, mrow, mbase, mcolbase, mcs, mrs, mcp, mpe, mpel;

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; mpos = 0; mrow = 0; mbase = 0; mcolbase = 0;
      mcs = 0; mrs = 0; mcp = 0; mpe = 0; mpel = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      if (mpos == 313) begin
        mpos = 0;
        mcolbase = (mcs / 8) % 16;
        if (mrow == 127) begin
          mrow = 0;
          mbase = (mrs % 32) * 4 + (mrs / 32) % 4;
          mpel = mpe;
        end else begin
          mrow++;
        end
      end else begin
        mpos++;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: mcs = wr_data % 128;
          2'd1: mrs = wr_data % 128;
          2'd2: mcp = wr_data % 16;
          default: mpe = wr_data % 2;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      int rc, col, pl, eshift;
      rc = (mbase + mrow) % 128;
      eshift = (mpos < 256) ? 1 : 0;
      col = eshift ? (mcolbase + mpos / 16) % 16 : mcolbase;
      pl = mpel ? rc % 4 : 0;
      check(ram_addr[3:0] == col[3:0], "R4 column", ram_addr[3:0], col);
      check(ram_addr[8:4] == 5'(rc / 4), "R5 row", ram_addr[8:4], rc / 4);
      check(ram_addr[10:9] == pl[1:0], "R6 plane", ram_addr[10:9], pl);
      check(ram_addr[14:11] == mcp[3:0], "R8 codepage", ram_addr[14:11], mcp);
      check(shift_en == eshift[0] && col_latch == !eshift[0] &&
            dot_clk == (eshift[0] && mpos % 2 == 1), "R2 phases",
            {dot_clk, shift_en, col_latch}, mpos);
      check(row_adv == (mpos == 313), "R3 row_adv", row_adv, mpos == 313);
      check(irq == (mpos == 313 && mrow == 127), "R7 irq", irq, mpos == 313 && mrow == 127);
    end
  end

  // interval measurements
  int last_irq = -1, last_adv = -1, last_adv_d = -1, adv_d_seen = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      if (irq) begin
        if (last_irq >= 0) check(cyc - last_irq == 40192, "R7 irq period", cyc - last_irq, 40192);
        last_irq = cyc;
      end
      if (row_adv) begin
        if (last_adv >= 0) check(cyc - last_adv == 314, "R1 direct row period", cyc - last_adv, 314);
        last_adv = cyc;
      end
      if (row_adv_d && adv_d_seen < 6) begin
        if (last_adv_d >= 0) check(cyc - last_adv_d == 1256, "R1 divided row period", cyc - last_adv_d, 1256);
        last_adv_d = cyc;
        adv_d_seen++;
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq();
    while (irq) @(negedge clk);
    while (!irq) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
    repeat (4) @(negedge clk);
    // R10 reset state on both variants
    check(ram_addr == 15'd0 && ram_addr_d == 15'd0, "R10 reset addr", ram_addr, 0);
    check(!irq && !row_adv && !irq_d && !row_adv_d, "R10 reset pulses", {irq, row_adv}, 0);
    check(shift_en && !dot_clk && !col_latch, "R10 reset phase", {shift_en, dot_clk, col_latch}, 4);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h2B);   // R4: column 5, low shift bits set but ignored
    wr(2'd1, 8'h65);   // row 5, plane source 3
    wr(2'd3, 8'h01);
    repeat (1000) @(negedge clk);
    wr(2'd0, 8'h7F);   // R4 column change picked up at next row start
    wait_irq();
    // R9 collision: write ROWSTART on the interrupt edge
    wr(2'd1, 8'h1F);
    check(ram_addr[8:4] == 5'd5, "R9 reload uses old rowstart", ram_addr[8:4], 5);
    check(ram_addr[10:9] == 2'd3, "R6 plane from rowstart", ram_addr[10:9], 3);
    repeat (20000) @(negedge clk);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h0A);
    wait_irq();
    wait_irq();
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h67);
    while (!irq_d) @(negedge clk);
    @(negedge clk);
    check(ram_addr_d[8:4] == 5'd7, "R7 divided reload row", ram_addr_d[8:4], 7);
    check(ram_addr_d[10:9] == 2'd1, "R6 divided fixed plane", ram_addr_d[10:9], 1);
    check(ram_addr_d[14:11] == 4'hA, "R8 divided codepage", ram_addr_d[14:11], 10);
    repeat (50) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule